// File: doc/BRIEF.md
# Cross-Channel Fail-Safe Power Interlock

This block supervises a pair of redundant processor channels that compute the same result. Each channel presents a result code with a one-cycle valid strobe. The interlock compares the two codes. While they keep agreeing, it holds both channels' power-enable and communication-enable outputs high.

Any disagreement forces the module into a latched safe state. A missing partner result, or a local fault flag raised by either channel, has the same effect. A code mismatch, a window expiry and a local fault are all ORed into a single kill term. Communication is cut in the cycle the kill term appears. Channel A loses power on the next edge. Channel B's power is derived from channel A's, so it falls one cycle later. The pair therefore behaves as a two-out-of-two structure.

The safe state can only be left through a maintenance clear, and only while no kill condition is present. After that, and after reset, every enable stays low until a fresh pair of matching codes arrives.

Top module: `xchan_power_interlock`

## Requirements
- R1: After reset, all four enables and `safe_latched` are low. They stay low until the first pair of matching codes is received.
- R2: When both channels present valid and equal codes, the following happens:
  - `a_pwr_en` and `a_com_en` go high on the next clock edge.
  - `b_pwr_en` and `b_com_en` go high one edge after that.
- R3: The two strobes need not coincide. A channel's code is held from its strobe. The partner's strobe may come in the same cycle or in any of the following WIN-1 cycles, and the two codes are then compared.
- R4: If the partner strobe has not arrived by the WIN-th cycle after the first strobe, that cycle is treated as a mismatch.
- R5: Two compared codes that differ cause a kill, whether the strobes came in the same cycle or in different cycles.
- R6: A high `a_fault` or `b_fault` causes a kill in any state, including before the first match.
- R7: Both communication enables are low in the same cycle as any kill condition.
- R8: `a_pwr_en` is low from the first clock edge after a kill. `b_pwr_en` follows `a_pwr_en` with one cycle of delay.
- R9: `safe_latched` rises on the edge after a kill and then holds. While it is high, all enables stay low and matching code pairs are ignored.
- R10: `maint_clr` sampled while latched with no kill present clears the latch. The block then returns to waiting for a match with all enables low. `maint_clr` sampled while a kill condition is present has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_code | input | CODE_W | Channel A result code |
| a_valid | input | 1 | Channel A code strobe |
| b_code | input | CODE_W | Channel B result code |
| b_valid | input | 1 | Channel B code strobe |
| a_fault | input | 1 | Channel A local fault flag |
| b_fault | input | 1 | Channel B local fault flag |
| maint_clr | input | 1 | Maintenance clear of the latched safe state |
| a_pwr_en | output | 1 | Channel A power enable |
| b_pwr_en | output | 1 | Channel B power enable (cascaded from A) |
| a_com_en | output | 1 | Channel A communication enable |
| b_com_en | output | 1 | Channel B communication enable |
| safe_latched | output | 1 | Latched module-wide shutdown status |

## Verification
The comparison is exercised with the following patterns:
- Equal codes in the same cycle, which shows the start-up order of the four enables.
- Equal codes strobed at the last cycle the window allows, which separates a correct window length from one that is one cycle short.
- A lone strobe, with the outputs checked both one cycle before and in the cycle the window expires.
- Unequal codes, delivered both in the same cycle and staggered, which separates the comparison of held codes from the comparison of live codes.
- Fault flags raised while running and while still waiting for the first match, together with a maintenance clear attempted while a fault is held. These show that the kill term is an OR of independent causes and that the latch refuses to clear under a live kill.

// File: rtl/xchan_power_interlock.sv
module xchan_power_interlock #(
  parameter int CODE_W = 8,
  parameter int WIN    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] a_code,
  input  logic              a_valid,
  input  logic [CODE_W-1:0] b_code,
  input  logic              b_valid,
  input  logic              a_fault,
  input  logic              b_fault,
  input  logic              maint_clr,
  output logic              a_pwr_en,
  output logic              b_pwr_en,
  output logic              a_com_en,
  output logic              b_com_en,
  output logic              safe_latched
);
  localparam int CNT_W = $clog2(WIN) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN - 1);

  logic              a_got, b_got, a_pwr_q, b_pwr_q, shut_q;
  logic [CODE_W-1:0] a_hold, b_hold;
  logic [CNT_W-1:0]  wait_cnt;

  logic [CODE_W-1:0] a_eff, b_eff;
  logic              pair_done, code_match, code_miss, win_out, kill;

  assign a_eff      = a_got ? a_hold : a_code;
  assign b_eff      = b_got ? b_hold : b_code;
  assign pair_done  = (a_got | a_valid) & (b_got | b_valid);
  assign code_match = pair_done & (a_eff == b_eff);
  assign code_miss  = pair_done & (a_eff != b_eff);
  assign win_out    = (a_got ^ b_got) & ~pair_done & (wait_cnt == LAST);
  assign kill       = code_miss | win_out | a_fault | b_fault;

  // result capture and pairing window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_got    <= 1'b0;
      b_got    <= 1'b0;
      a_hold   <= '0;
      b_hold   <= '0;
      wait_cnt <= '0;
    end else if (pair_done || win_out || shut_q) begin
      a_got    <= 1'b0;
      b_got    <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (a_valid && !a_got) begin
        a_got  <= 1'b1;
        a_hold <= a_code;
      end
      if (b_valid && !b_got) begin
        b_got  <= 1'b1;
        b_hold <= b_code;
      end
      wait_cnt <= (a_got ^ b_got) ? wait_cnt + 1'b1 : '0;
    end
  end

  // power chain: A from both checks, B cascaded from A
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pwr_q <= 1'b0;
      b_pwr_q <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      a_pwr_q <= ~kill & ~shut_q & (a_pwr_q | code_match);
      b_pwr_q <= a_pwr_q;
      shut_q  <= kill | (shut_q & ~maint_clr);
    end
  end

  assign a_pwr_en     = a_pwr_q;
  assign b_pwr_en     = b_pwr_q;
  assign a_com_en     = a_pwr_q & ~kill;
  assign b_com_en     = b_pwr_q & a_pwr_q & ~kill;
  assign safe_latched = shut_q;

  AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n)
    b_pwr_en |-> $past(a_pwr_en)); // R8
  AST_KILL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> safe_latched && !a_pwr_en); // R9
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    safe_latched && !maint_clr |=> safe_latched); // R9
  AST_SAFE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    safe_latched |-> !a_pwr_en && !a_com_en && !b_com_en); // R9
  AST_PWR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_pwr_en) |-> $past(code_match)); // R2
  AST_FAULT_CUTS_COMMS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fault || b_fault) |-> !a_com_en && !b_com_en); // R6
endmodule

// File: tb/xchan_power_interlock_tb_top.sv
module xchan_power_interlock_tb_top;
  localparam int CODE_W = 8;
  localparam int WIN    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CODE_W-1:0] a_code = '0, b_code = '0;
  logic a_valid = 1'b0, b_valid = 1'b0, a_fault = 1'b0, b_fault = 1'b0, maint_clr = 1'b0;
  logic a_pwr_en, b_pwr_en, a_com_en, b_com_en, safe_latched;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xchan_power_interlock #(.CODE_W(CODE_W), .WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_code(a_code), .a_valid(a_valid),
    .b_code(b_code), .b_valid(b_valid), .a_fault(a_fault), .b_fault(b_fault),
    .maint_clr(maint_clr), .a_pwr_en(a_pwr_en), .b_pwr_en(b_pwr_en),
    .a_com_en(a_com_en), .b_com_en(b_com_en), .safe_latched(safe_latched));

  // expected vector order: {a_pwr, b_pwr, a_com, b_com, safe}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    #1;
    act = {a_pwr_en, b_pwr_en, a_com_en, b_com_en, safe_latched};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_maint();
    maint_clr = 1'b1;
    step();
    maint_clr = 1'b0;
    chk("R10 cleared", 5'b00000);
  endtask

  task automatic t_reset();
    chk("R1 reset state", 5'b00000);
    repeat (4) step();
    chk("R1 idle without codes", 5'b00000);
  endtask

  task automatic t_match_same(input logic [CODE_W-1:0] c);
    a_code = c; b_code = c; a_valid = 1'b1; b_valid = 1'b1;
    chk("R1 low before first match", 5'b00000);
    step();
    a_valid = 1'b0; b_valid = 1'b0;
    chk("R2 channel A up", 5'b10100);
    step();
    chk("R2 channel B up", 5'b11110);
  endtask

  task automatic t_staggered();
    a_code = 8'h33; a_valid = 1'b1;
    step();
    a_valid = 1'b0;
    repeat (WIN - 2) step();
    b_code = 8'h33; b_valid = 1'b1;
    chk("R3 last window cycle", 5'b11110);
    step();
    b_valid = 1'b0;
    chk("R3 late match accepted", 5'b11110);
    repeat (WIN) step();
    chk("R3 no spurious timeout", 5'b11110);
  endtask

  task automatic t_timeout();
    a_code = 8'h77; a_valid = 1'b1;
    step();
    a_valid = 1'b0;
    repeat (WIN - 2) step();
    chk("R4 before expiry", 5'b11110);
    step();
    chk("R4 R7 expiry cuts comms", 5'b11000);
    step();
    chk("R8 A power off first", 5'b01001);
    step();
    chk("R8 B power off next", 5'b00001);
  endtask

  task automatic t_latched_ignore();
    a_code = 8'h5A; b_code = 8'h5A; a_valid = 1'b1; b_valid = 1'b1;
    step();
    a_valid = 1'b0; b_valid = 1'b0;
    chk("R9 match ignored while latched", 5'b00001);
    step();
    chk("R9 latch holds", 5'b00001);
  endtask

  task automatic t_mismatch_same();
    a_code = 8'h11; b_code = 8'h12; a_valid = 1'b1; b_valid = 1'b1;
    chk("R5 R7 mismatch cuts comms", 5'b11000);
    step();
    a_valid = 1'b0; b_valid = 1'b0;
    chk("R5 R8 A off", 5'b01001);
    step();
    chk("R8 B off", 5'b00001);
  endtask

  task automatic t_mismatch_stagger();
    a_code = 8'h44; a_valid = 1'b1;
    step();
    a_valid = 1'b0; a_code = 8'h45;
    step();
    b_code = 8'h45; b_valid = 1'b1;
    chk("R5 held code compared", 5'b11000);
    step();
    b_valid = 1'b0;
    chk("R5 staggered mismatch latches", 5'b01001);
    step();
  endtask

  task automatic t_fault();
    b_fault = 1'b1;
    chk("R6 R7 fault cuts comms", 5'b11000);
    step();
    chk("R6 fault removes A power", 5'b01001);
    maint_clr = 1'b1;
    step();
    maint_clr = 1'b0;
    chk("R10 clear refused under fault", 5'b00001);
    b_fault = 1'b0;
    do_maint();
    repeat (3) step();
    chk("R10 R1 waits for fresh match", 5'b00000);
  endtask

  task automatic t_fault_armed();
    a_fault = 1'b1;
    step();
    a_fault = 1'b0;
    chk("R6 fault before first match latches", 5'b00001);
    step();
    chk("R9 latch holds after fault gone", 5'b00001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_match_same(8'h5A);
    t_staggered();
    t_timeout();
    t_latched_ignore();
    do_maint();
    t_match_same(8'hC3);
    t_mismatch_same();
    do_maint();
    t_match_same(8'h0F);
    t_mismatch_stagger();
    do_maint();
    t_match_same(8'hA5);
    t_fault();
    t_fault_armed();
    do_maint();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule